// File: doc/BRIEF.md
# Dual Down-Counting Reload Timer

This block holds two independent 32-bit timers behind a small register bus. Each timer has a live count register and a reload register. On every count tick the count drops by one. When the count reaches zero the timer raises its event flag. It then either restarts from the reload value or stops and disarms itself, depending on the auto-reload bit.

A shared control register sets up each timer: a run bit, an auto-reload bit, a source select and a 3-bit divide exponent. The source select picks one of two tick sources. The first is an external reference tick-enable input. The second is the system clock divided by a power of two. A shared status register holds the two event flags. Each flag drives an interrupt output as a level. Software clears a flag by writing zero to its bit.

The bus is single-cycle. A write takes effect at the clock edge where the write strobe is high. Read data is a combinational view of the addressed register as it stands in the current cycle.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset the control and status registers read 0, both count and both reload registers read 0xFFFFFFFF, and both interrupt outputs are low.
- R2: Registers are selected by address bits 4:2, and address bits 1:0 are ignored. The byte offsets are: control 0x00, status 0x04, timer-0 reload 0x10, timer-0 count 0x14, timer-1 reload 0x18, timer-1 count 0x1C. Offsets 0x08 and 0x0C read 0, and writes to them change nothing.
- R3: Control bit layout. Timer 0 uses run bit 0, auto-reload bit 1, reference-source bit 11 and divide exponent bits 21:19. Timer 1 uses run bit 2, auto-reload bit 3, reference-source bit 12 and divide exponent bits 24:22. All other control bits read 0.
- R4: With the reference-source bit clear and divide exponent n, a running timer ticks once every 2^n clock cycles. Each timer's prescaler restarts when the timer is stopped, so the first tick lands on the 2^n-th clock edge after the edge that set the run bit.
- R5: With the reference-source bit set, a running timer ticks on every clock edge at which `ref_tick` is high, whatever the divide exponent.
- R6: Each tick lowers a non-zero count by one. A bus write to a count register takes priority over a tick in the same cycle.
- R7: With auto-reload set, a tick at count zero loads the reload value, so a reload value of N-1 gives one event every N ticks.
- R8: With auto-reload clear, a tick that brings the count to zero clears that timer's run bit and the count stays at zero. A tick at count zero with auto-reload clear also clears the run bit but raises no event. A control write in the same cycle overrides the self-clear.
- R9: An event is a tick that leaves the count at zero, except the one-shot tick that starts at zero. An event sets status bit 0 for timer 0 or status bit 8 for timer 1.
- R10: Writing 0 to a status bit clears it and writing 1 leaves it unchanged. An event in the same cycle as a clearing write keeps the bit set. `irq[0]` follows status bit 0 and `irq[1]` follows status bit 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, current cycle |
| ref_tick | input | 1 | Reference tick enable, used by timers with the reference-source bit set |
| irq | output | 2 | Per-timer interrupt level, bit i for timer i |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions. One is a status-clear write landing on the exact edge where the timer raises a new event. The other is a count write landing on the exact edge where a tick would decrement. The directed stimulus runs timer 0 with divide-by-one and a reload of 3, so events repeat every four edges. The bench counts edges from the control write and issues the clearing write so it coincides with the event edge. A long random phase then keeps reload and count values below eight and toggles `ref_tick` at random. This makes both collisions, and one-shot ticks at zero, happen often. A behavioural model checks every cycle of that phase.

// File: rtl/drt_pkg.sv
// Package: drt_pkg
// Shared sizes, register word indices and control/status bit placement for
// the dual reload timer. Assumes two timers and 32-bit registers; the control
// field positions are fixed by the register layout and need DATA_W >= 25.
package drt_pkg;

    localparam int DATA_W  = 32;
    localparam int NUM_TMR = 2;
    localparam int DIV_W   = 3;
    localparam int ADDR_W  = 5;
    localparam int WSEL_W  = ADDR_W - 2;

    // Word index of each register (byte address bits 4:2)
    typedef enum logic [WSEL_W-1:0] {
        W_CTRL  = 3'd0,
        W_STAT  = 3'd1,
        W_GAP2  = 3'd2,
        W_GAP3  = 3'd3,
        W_RLD0  = 3'd4,
        W_CNT0  = 3'd5,
        W_RLD1  = 3'd6,
        W_CNT1  = 3'd7
    } word_e;

    // Per-timer configuration decoded from the control register
    typedef struct packed {
        logic             run;
        logic             autold;
        logic             use_ref;
        logic [DIV_W-1:0] div;
    } tmr_cfg_t;

    function automatic int run_pos(input int t);
        return 2 * t;
    endfunction

    function automatic int ar_pos(input int t);
        return 2 * t + 1;
    endfunction

    function automatic int src_pos(input int t);
        return 11 + t;
    endfunction

    function automatic int div_pos(input int t);
        return 19 + DIV_W * t;
    endfunction

    function automatic int flag_pos(input int t);
        return 8 * t;
    endfunction

    function automatic int rld_word(input int t);
        return 4 + 2 * t;
    endfunction

    function automatic int cnt_word(input int t);
        return 5 + 2 * t;
    endfunction

    // Bits of the control register that hold state
    function automatic logic [DATA_W-1:0] ctrl_keep();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int t = 0; t < NUM_TMR; t++) begin
            m[run_pos(t)]              = 1'b1;
            m[ar_pos(t)]               = 1'b1;
            m[src_pos(t)]              = 1'b1;
            m[div_pos(t) +: DIV_W]     = '1;
        end
        return m;
    endfunction

    // Bits of the status register that hold state
    function automatic logic [DATA_W-1:0] stat_keep();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int t = 0; t < NUM_TMR; t++) begin
            m[flag_pos(t)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/drt_tick_gen.sv
// Module: drt_tick_gen
// Produces the count-enable pulse for one timer. It picks either the
// external reference tick or a power-of-two division of the system clock.
// Assumes ref_tick is already synchronous to clk. The prescaler counter is
// private to the timer and is held at zero while the timer is stopped.
module drt_tick_gen #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             use_ref,
    input  logic             ref_tick,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);

    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_mask;

    // Low-bit mask whose all-ones state marks the end of a 2^n window
    always_comb pre_mask = ~({PRE_W{1'b1}} << div_sel);

    // Free-running prescaler, restarted whenever the timer is stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // Tick select between reference input and prescaler window end
    always_comb begin
        if (!run) begin
            tick = 1'b0;
        end else if (use_ref) begin
            tick = ref_tick;
        end else begin
            tick = ((pre_q & pre_mask) == pre_mask);
        end
    end

    // The prescaler must start from zero on every start of the timer
    p_prescale_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (pre_q == '0));

endmodule

// File: rtl/drt_counter.sv
// Module: drt_counter
// One 32-bit down counter with its reload register. On a tick it decrements,
// or at zero either reloads (auto-reload) or holds at zero (one-shot). It
// reports an event and, for one-shot use, a request to clear the run bit.
// Assumes bus writes and ticks are single-cycle strobes in the clk domain.
module drt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         auto_reload,
    input  logic         val_wr,
    input  logic         rld_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output logic [W-1:0] reload,
    output logic         expire,
    output logic         stop
);

    logic         at_zero;
    logic [W-1:0] step;

    // Next count if a tick is applied this cycle
    always_comb begin
        at_zero = (value == '0);
        if (!at_zero) begin
            step = value - W'(1);
        end else if (auto_reload) begin
            step = reload;
        end else begin
            step = '0;
        end
    end

    // Event when a tick leaves the count at zero, except a one-shot idle tick
    assign expire = tick && (step == '0) && (!at_zero || auto_reload);

    // One-shot timers disarm on the tick that ends at zero
    assign stop = tick && (step == '0) && !auto_reload;

    // Live count: bus write first, then tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '1;
        end else if (val_wr) begin
            value <= wdata;
        end else if (tick) begin
            value <= step;
        end
    end

    // Reload register, written by the bus only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '1;
        end else if (rld_wr) begin
            reload <= wdata;
        end
    end

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !at_zero && !val_wr) |=> (value == $past(value) - W'(1)));

    p_write_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        val_wr |=> (value == $past(wdata)));

    p_reload_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_zero && auto_reload && !val_wr) |=> (value == $past(reload)));

    p_hold_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_zero && !auto_reload && !val_wr) |=> (value == '0));

endmodule

// File: rtl/dual_reload_timer.sv
// Module: dual_reload_timer
// Register front end for two down-counting timers. It holds the shared
// control and status registers, decodes the single-cycle bus and drives one
// interrupt level per timer. Assumes bus_addr is stable while bus_wr is high
// and that reads are combinational in the cycle they are presented.
module dual_reload_timer
    import drt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                ref_tick,
    output logic [NUM_TMR-1:0]  irq
);

    localparam logic [DATA_W-1:0] CTRL_KEEP = ctrl_keep();
    localparam logic [DATA_W-1:0] STAT_KEEP = stat_keep();

    logic [DATA_W-1:0] ctrl_q, ctrl_d;
    logic [DATA_W-1:0] stat_q, stat_d;
    word_e             wsel;
    logic              ctrl_wr, stat_wr;
    logic              unused_lsb;

    tmr_cfg_t          cfg     [NUM_TMR];
    logic [DATA_W-1:0] cnt_val [NUM_TMR];
    logic [DATA_W-1:0] rld_val [NUM_TMR];
    logic [NUM_TMR-1:0] tick, expire, stop, val_wr, rld_wr;

    // Word decode of the byte address
    assign wsel       = word_e'(bus_addr[ADDR_W-1:2]);
    assign unused_lsb = ^bus_addr[1:0];
    assign ctrl_wr    = bus_wr && (wsel == W_CTRL);
    assign stat_wr    = bus_wr && (wsel == W_STAT);

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        localparam int RP = run_pos(g);
        localparam int AP = ar_pos(g);
        localparam int SP = src_pos(g);
        localparam int DP = div_pos(g);
        localparam int FP = flag_pos(g);
        localparam logic [WSEL_W-1:0] RW = WSEL_W'(rld_word(g));
        localparam logic [WSEL_W-1:0] CW = WSEL_W'(cnt_word(g));

        // Field extraction for this timer
        assign cfg[g].run     = ctrl_q[RP];
        assign cfg[g].autold  = ctrl_q[AP];
        assign cfg[g].use_ref = ctrl_q[SP];
        assign cfg[g].div     = ctrl_q[DP +: DIV_W];

        // Bus strobes for this timer's count and reload registers
        assign val_wr[g] = bus_wr && (bus_addr[ADDR_W-1:2] == CW);
        assign rld_wr[g] = bus_wr && (bus_addr[ADDR_W-1:2] == RW);

        drt_tick_gen #(
            .DIV_W    (DIV_W)
        ) u_tick (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (cfg[g].run),
            .use_ref  (cfg[g].use_ref),
            .ref_tick (ref_tick),
            .div_sel  (cfg[g].div),
            .tick     (tick[g])
        );

        drt_counter #(
            .W           (DATA_W)
        ) u_cnt (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick        (tick[g]),
            .auto_reload (cfg[g].autold),
            .val_wr      (val_wr[g]),
            .rld_wr      (rld_wr[g]),
            .wdata       (bus_wdata),
            .value       (cnt_val[g]),
            .reload      (rld_val[g]),
            .expire      (expire[g]),
            .stop        (stop[g])
        );

        // Interrupt level mirrors the flag
        assign irq[g] = stat_q[FP];

        p_event_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
            expire[g] |=> irq[g]);

        p_zero_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_wr && !bus_wdata[FP] && !expire[g]) |=> !irq[g]);

        p_one_shot_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (stop[g] && !ctrl_wr) |=> !ctrl_q[RP]);
    end

    // Control next state: bus write overrides one-shot self-clear
    always_comb begin
        ctrl_d = ctrl_q;
        for (int t = 0; t < NUM_TMR; t++) begin
            if (stop[t]) begin
                ctrl_d[run_pos(t)] = 1'b0;
            end
        end
        if (ctrl_wr) begin
            ctrl_d = bus_wdata & CTRL_KEEP;
        end
    end

    // Status next state: write-zero clear, then events set
    always_comb begin
        stat_d = stat_q;
        if (stat_wr) begin
            stat_d = stat_q & bus_wdata;
        end
        for (int t = 0; t < NUM_TMR; t++) begin
            if (expire[t]) begin
                stat_d[flag_pos(t)] = 1'b1;
            end
        end
        stat_d = stat_d & STAT_KEEP;
    end

    // Shared register state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            stat_q <= stat_d;
        end
    end

    // Combinational read mux
    always_comb begin
        case (wsel)
            W_CTRL:  bus_rdata = ctrl_q;
            W_STAT:  bus_rdata = stat_q;
            W_RLD0:  bus_rdata = rld_val[0];
            W_CNT0:  bus_rdata = cnt_val[0];
            W_RLD1:  bus_rdata = rld_val[1];
            W_CNT1:  bus_rdata = cnt_val[1];
            default: bus_rdata = '0;
        endcase
    end

    p_ctrl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl_q == ($past(bus_wdata) & CTRL_KEEP)));

endmodule

// File: tb/sim_dual_reload_timer.sv
// Bench for dual_reload_timer: directed scenarios plus a random phase, with a
// behavioural per-cycle model compared against the ports on every clock.
module sim_dual_reload_timer;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_tick = 1'b0;
    logic [1:0]  irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    dual_reload_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ref_tick  (ref_tick),
        .irq       (irq)
    );

    always #(PERIOD/2) clk = ~clk;

    // ---------------- behavioural model ----------------
    logic [31:0] m_ctrl, m_stat;
    logic [31:0] m_val [2];
    logic [31:0] m_rld [2];
    int          m_pre [2];
    logic [31:0] nc, ns, sm, nv0, nv1;

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a[4:2])
            3'd0: return m_ctrl;
            3'd1: return m_stat;
            3'd4: return m_rld[0];
            3'd5: return m_val[0];
            3'd6: return m_rld[1];
            3'd7: return m_val[1];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        case (a[4:2])
            3'd0: return "R3";
            3'd1: return "R10";
            3'd4, 3'd6: return "R7";
            3'd5, 3'd7: return "R6";
            default: return "R2";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_stat = 0;
            m_val[0] = '1; m_val[1] = '1; m_rld[0] = '1; m_rld[1] = '1;
            m_pre[0] = 0; m_pre[1] = 0;
        end else begin
            nc = m_ctrl; sm = 0;
            for (int i = 0; i < 2; i++) begin
                logic en, ar, rs, tk;
                int dv;
                logic [31:0] v;
                en = m_ctrl[2*i]; ar = m_ctrl[2*i+1]; rs = m_ctrl[11+i];
                dv = int'((m_ctrl >> (19 + 3*i)) & 32'h7);
                tk = en && (rs ? ref_tick : ((m_pre[i] % (1 << dv)) == (1 << dv) - 1));
                v = m_val[i];
                if (tk) begin
                    if (m_val[i] == 0) begin
                        if (ar) begin
                            v = m_rld[i];
                            if (m_rld[i] == 0) sm[8*i] = 1'b1;
                        end else begin
                            nc[2*i] = 1'b0;
                        end
                    end else begin
                        v = m_val[i] - 1;
                        if (v == 0) begin
                            sm[8*i] = 1'b1;
                            if (!ar) nc[2*i] = 1'b0;
                        end
                    end
                end
                if (i == 0) nv0 = v; else nv1 = v;
                m_pre[i] = en ? (m_pre[i] + 1) % 128 : 0;
            end
            ns = m_stat;
            if (bus_wr && bus_addr[4:2] == 3'd1) ns = ns & bus_wdata;
            ns = ns | sm;
            if (bus_wr && bus_addr[4:2] == 3'd0) nc = bus_wdata & 32'h01F8180F;
            if (bus_wr && bus_addr[4:2] == 3'd5) nv0 = bus_wdata;
            if (bus_wr && bus_addr[4:2] == 3'd7) nv1 = bus_wdata;
            if (bus_wr && bus_addr[4:2] == 3'd4) m_rld[0] = bus_wdata;
            if (bus_wr && bus_addr[4:2] == 3'd6) m_rld[1] = bus_wdata;
            m_ctrl = nc; m_stat = ns; m_val[0] = nv0; m_val[1] = nv1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R10 irq", {30'd0, irq}, {30'd0, m_stat[8], m_stat[0]});
            check(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R6 actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset values
        chk(5'h00, 32'h0, "R1 ctrl");
        chk(5'h04, 32'h0, "R1 status");
        check("R1 irq", {30'd0, irq}, 32'h0);
        step();
        chk(5'h10, 32'hFFFFFFFF, "R1 reload0");
        chk(5'h14, 32'hFFFFFFFF, "R1 count0");
        chk(5'h18, 32'hFFFFFFFF, "R1 reload1");
        step();
        chk(5'h1C, 32'hFFFFFFFF, "R1 count1");
        // R2: gaps read zero, low bits ignored, gap writes inert
        chk(5'h08, 32'h0, "R2 gap 0x08");
        chk(5'h17, 32'hFFFFFFFF, "R2 low bits ignored");
        wr(5'h0C, 32'hFFFFFFFF);
        chk(5'h0C, 32'h0, "R2 gap 0x0C");
        chk(5'h00, 32'h0, "R2 gap write inert");
        // R3: control bit layout
        wr(5'h00, 32'hFFFFFFFF);
        chk(5'h00, 32'h01F8180F, "R3 ctrl mask");
        wr(5'h00, 32'h0);

        // R7/R9: periodic timer 0, reload 3, divide by 1
        wr(5'h10, 32'd3);
        wr(5'h14, 32'd3);
        wr(5'h00, 32'h3);
        chk(5'h14, 32'd3, "R6 start");
        step(); step();
        chk(5'h14, 32'd1, "R6 decrement");
        step();
        chk(5'h14, 32'd0, "R9 at zero");
        check("R9 irq0 set", {31'd0, irq[0]}, 32'd1);
        step();
        chk(5'h14, 32'd3, "R7 reload");
        // R10: clear by zero, then collision with event
        wr(5'h04, 32'hFFFFFFFE);
        check("R10 cleared", {31'd0, irq[0]}, 32'd0);
        step();
        chk(5'h14, 32'd1, "R7 period");
        wr(5'h04, 32'h0);
        check("R10 event wins", {31'd0, irq[0]}, 32'd1);

        // R4/R8: one-shot timer 1, divide by 4
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0);
        wr(5'h1C, 32'd5);
        wr(5'h00, 32'h00800004);
        for (int k = 0; k < 19; k++) step();
        chk(5'h1C, 32'd1, "R4 prescaled timing");
        check("R9 no early irq1", {31'd0, irq[1]}, 32'd0);
        step();
        chk(5'h1C, 32'd0, "R4 last tick");
        check("R9 irq1 set", {31'd0, irq[1]}, 32'd1);
        chk(5'h00, 32'h00800000, "R8 run bit cleared");
        for (int k = 0; k < 8; k++) step();
        chk(5'h1C, 32'd0, "R8 holds zero");
        wr(5'h04, 32'hFFFFFFFE);
        check("R10 write one keeps", {31'd0, irq[1]}, 32'd1);

        // R5: reference source ignores divide exponent
        wr(5'h04, 32'h0);
        wr(5'h14, 32'd10);
        wr(5'h00, 32'h00380801);
        ref_tick = 1'b1;
        step(); step(); step();
        ref_tick = 1'b0;
        chk(5'h14, 32'd7, "R5 ref ticks");
        for (int k = 0; k < 5; k++) step();
        chk(5'h14, 32'd7, "R5 idle ref");

        // R6: count write beats a tick
        wr(5'h00, 32'h1);
        step();
        chk(5'h14, 32'd6, "R6 div1 tick");
        wr(5'h14, 32'd100);
        chk(5'h14, 32'd100, "R6 write wins");
        step();
        chk(5'h14, 32'd99, "R6 after write");

        // R8: one-shot tick at zero disarms silently
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0);
        wr(5'h14, 32'd0);
        wr(5'h00, 32'h1);
        step();
        chk(5'h00, 32'h0, "R8 idle disarm");
        chk(5'h14, 32'd0, "R8 idle count");
        check("R9 no idle event", {31'd0, irq[0]}, 32'd0);

        // Random phase: small counts, random sources, collisions
        for (int k = 0; k < 4000; k++) begin
            ref_tick = 1'($urandom % 2);
            if ($urandom % 4 == 0) begin
                logic [2:0] w;
                logic [31:0] d;
                w = 3'($urandom % 8);
                d = (w >= 3'd4) ? 32'($urandom % 8) : $urandom;
                if (w == 3'd0 && ($urandom % 2 == 1)) d = d & 32'hFF03FFFF;
                wr({w, 2'b00}, d);
            end else begin
                bus_addr = 5'($urandom % 32);
                step();
            end
        end
        step();
        summary();
        $finish;
    end

endmodule